// File: doc/BRIEF.md
# Read-Address Key Sequence Detector

This block sits beside a parallel asynchronous memory bus and watches for a hidden command. The command is six reads in a row from fixed addresses. The first five addresses act as an unlock key. The sixth address picks the action: save the working memory into its nonvolatile copy, or reload the working memory from that copy. When the sequence completes, the block raises a single-cycle store or recall request toward a separate engine that does the transfer.

The sequence has no command register behind it. Any write, or any read from the wrong address, silently drops the partial sequence. Bus accesses are counted on the falling edge of the active-low chip enable. The block brings that level through a synchronizer into the system clock domain before detecting the edge. The write-enable level and the address are delayed by the same number of stages, so they line up with the detected edge.

The store request is blocked while a low-voltage inhibit flag is high. While the downstream engine reports busy, every access is ignored. A debug count shows how many keys have matched so far.

Top module: `keySeqDetector`

## Requirements
- R1: After reset, `progress` is 0 and both `storeReq` and `recallReq` are low.
- R2: The keys 0x0E38, 0x31C7, 0x03E0, 0x3C1F and 0x303F, read in that order, step `progress` through 1, 2, 3, 4 and 5.
- R3: At progress 5, a read from 0x0FC0 gives a one-cycle `storeReq` pulse, and `progress` returns to 0.
- R4: At progress 5, a read from 0x0C63 gives a one-cycle `recallReq` pulse, and `progress` returns to 0.
- R5: Only address bits 13 to 0 are compared. Bit 14 and any higher bits have no effect on matching.
- R6: An access with `weN` low, at any step, clears `progress` to 0 and issues no command.
- R7: A read that does not match the expected key aborts the sequence. If that read's address equals the first key (0x0E38), `progress` becomes 1; otherwise it becomes 0.
- R8: Each falling edge of `ceN` counts as exactly one access, no matter how long `ceN` stays low. A command pulse appears on the third rising clock edge after the sixth falling edge is set up.
- R9: While `lowVoltInhibit` is high, a completed store sequence issues no `storeReq` and returns `progress` to 0. A recall sequence is not affected by this flag.
- R10: While `engineBusy` is high, accesses are ignored, `progress` is held at 0, and no request is issued.
- R11: `storeReq` and `recallReq` are never high together, and neither is high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous active-low reset |
| ceN | input | 1 | Bus chip enable, active low, asynchronous to `clk` |
| weN | input | 1 | Bus write enable, active low |
| addr | input | ADDR_W | Bus address |
| lowVoltInhibit | input | 1 | Blocks store requests while high |
| engineBusy | input | 1 | Downstream transfer engine is busy |
| storeReq | output | 1 | One-cycle save request |
| recallReq | output | 1 | One-cycle reload request |
| progress | output | 3 | Number of keys matched so far (0 to 5) |

## Verification
The embedded assertions check the structural rules on every cycle:
- The two requests are mutually exclusive and last one cycle.
- A request only follows a cycle in which the matcher stood at step 5.
- No store request follows a cycle with the inhibit flag high.
- Busy forces the matcher back to idle.
- Progress only ever advances by one or falls back to 0 or 1.
- The edge strobe from the synchronizer lasts one cycle.

Only the bench scenarios can show the rest:
- The exact key values and their order decide whether progress advances.
- The upper address bit is ignored.
- A write or a stray read part-way through cancels the command.
- An aborting read of the first key restarts the sequence at step 1.
- A chip enable held low is counted once.

// File: rtl/keySeqPkg.sv
package keySeqPkg;

  localparam int KEY_W    = 14;
  localparam int NUM_KEYS = 5;
  localparam int STEP_W   = 3;

  localparam logic [KEY_W-1:0] STORE_KEY  = 14'h0FC0;
  localparam logic [KEY_W-1:0] RECALL_KEY = 14'h0C63;

  // Unlock keys, in the order they must be read.
  function automatic logic [KEY_W-1:0] keyAt(input logic [STEP_W-1:0] idx);
    case (idx)
      3'd0:    keyAt = 14'h0E38;
      3'd1:    keyAt = 14'h31C7;
      3'd2:    keyAt = 14'h03E0;
      3'd3:    keyAt = 14'h3C1F;
      3'd4:    keyAt = 14'h303F;
      default: keyAt = '1;
    endcase
  endfunction

  // Strobes from the datapath to the control.
  typedef struct packed {
    logic access;       // one-cycle strobe: falling edge of chip enable
    logic isWrite;      // write enable was low for this access
    logic hitExpected;  // address matches the key expected at the current step
    logic hitFirst;     // address matches the first key
    logic hitStore;     // address matches the store selector
    logic hitRecall;    // address matches the recall selector
  } dpEvt_t;

endpackage

// File: rtl/keySeqDatapath.sv
module keySeqDatapath
  import keySeqPkg::*;
#(
  parameter int ADDR_W      = 15,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              weN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [STEP_W-1:0] stepIdx,
  output dpEvt_t            evt
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] ceChain;
  logic [SYNC_STAGES-1:0] weChain;
  logic [KEY_W-1:0]       addrChain [SYNC_STAGES];
  logic                   cePrev;
  logic [KEY_W-1:0]       addrNow;
  logic                   ceFall;

  generate
    if (ADDR_W > KEY_W) begin : g_hiBits
      logic addrHiUnused;
      assign addrHiUnused = ^addr[ADDR_W-1:KEY_W];
    end
  endgenerate

  genvar s;
  generate
    for (s = 0; s < SYNC_STAGES; s++) begin : g_sync
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rstN) begin
            ceChain[0]   <= 1'b1;
            weChain[0]   <= 1'b1;
            addrChain[0] <= '0;
          end else begin
            ceChain[0]   <= ceN;
            weChain[0]   <= weN;
            addrChain[0] <= addr[KEY_W-1:0];
          end
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rstN) begin
            ceChain[s]   <= 1'b1;
            weChain[s]   <= 1'b1;
            addrChain[s] <= '0;
          end else begin
            ceChain[s]   <= ceChain[s-1];
            weChain[s]   <= weChain[s-1];
            addrChain[s] <= addrChain[s-1];
          end
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) cePrev <= 1'b1;
    else       cePrev <= ceChain[LAST];
  end

  assign ceFall  = cePrev & ~ceChain[LAST];
  assign addrNow = addrChain[LAST];

  always_comb begin
    evt.access      = ceFall;
    evt.isWrite     = ~weChain[LAST];
    evt.hitExpected = (stepIdx < STEP_W'(NUM_KEYS)) && (addrNow == keyAt(stepIdx));
    evt.hitFirst    = (addrNow == keyAt('0));
    evt.hitStore    = (addrNow == STORE_KEY);
    evt.hitRecall   = (addrNow == RECALL_KEY);
  end

  // R8: one strobe per falling edge, never two cycles long
  access_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    evt.access |=> !evt.access);

endmodule

// File: rtl/keySeqControl.sv
module keySeqControl
  import keySeqPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dpEvt_t            evt,
  input  logic              lowVoltInhibit,
  input  logic              engineBusy,
  output logic [STEP_W-1:0] step,
  output logic              storeReq,
  output logic              recallReq
);

  localparam logic [STEP_W-1:0] FINAL_STEP = STEP_W'(NUM_KEYS);

  logic [STEP_W-1:0] stepNext;
  logic              storeNext;
  logic              recallNext;
  logic [STEP_W-1:0] restartStep;

  assign restartStep = evt.hitFirst ? STEP_W'(1) : '0;

  always_comb begin
    stepNext   = step;
    storeNext  = 1'b0;
    recallNext = 1'b0;
    if (engineBusy) begin
      stepNext = '0;
    end else if (evt.access) begin
      if (evt.isWrite) begin
        stepNext = '0;
      end else if (step == FINAL_STEP) begin
        if (evt.hitStore) begin
          stepNext  = '0;
          storeNext = ~lowVoltInhibit;
        end else if (evt.hitRecall) begin
          stepNext   = '0;
          recallNext = 1'b1;
        end else begin
          stepNext = restartStep;
        end
      end else if (evt.hitExpected) begin
        stepNext = step + STEP_W'(1);
      end else begin
        stepNext = restartStep;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      step      <= '0;
      storeReq  <= 1'b0;
      recallReq <= 1'b0;
    end else begin
      step      <= stepNext;
      storeReq  <= storeNext;
      recallReq <= recallNext;
    end
  end

  // R11
  req_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(storeReq && recallReq));

  // R11
  store_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    storeReq |=> !storeReq);

  // R11
  recall_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    recallReq |=> !recallReq);

  // R3
  store_from_final_chk: assert property (@(posedge clk) disable iff (!rstN)
    storeReq |-> ($past(step) == FINAL_STEP && step == '0));

  // R4
  recall_from_final_chk: assert property (@(posedge clk) disable iff (!rstN)
    recallReq |-> ($past(step) == FINAL_STEP && step == '0));

  // R9
  store_inhibit_chk: assert property (@(posedge clk) disable iff (!rstN)
    storeReq |-> !$past(lowVoltInhibit));

  // R10
  busy_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    engineBusy |=> (step == '0 && !storeReq && !recallReq));

  // R6
  write_abort_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evt.access && evt.isWrite) |=> (step == '0 && !storeReq && !recallReq));

  // R2
  step_move_chk: assert property (@(posedge clk) disable iff (!rstN)
    (step != $past(step)) |-> (step <= STEP_W'(1) || step == $past(step) + STEP_W'(1)));

  // R2
  step_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    step <= FINAL_STEP);

endmodule

// File: rtl/keySeqDetector.sv
module keySeqDetector
  import keySeqPkg::*;
#(
  parameter int ADDR_W      = 15,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              weN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              lowVoltInhibit,
  input  logic              engineBusy,
  output logic              storeReq,
  output logic              recallReq,
  output logic [2:0]        progress
);

  dpEvt_t            evt;
  logic [STEP_W-1:0] step;

  keySeqDatapath #(
    .ADDR_W     (ADDR_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_datapath (
    .clk    (clk),
    .rstN   (rstN),
    .ceN    (ceN),
    .weN    (weN),
    .addr   (addr),
    .stepIdx(step),
    .evt    (evt)
  );

  keySeqControl u_control (
    .clk           (clk),
    .rstN          (rstN),
    .evt           (evt),
    .lowVoltInhibit(lowVoltInhibit),
    .engineBusy    (engineBusy),
    .step          (step),
    .storeReq      (storeReq),
    .recallReq     (recallReq)
  );

  assign progress = step;

endmodule

// File: tb/keySeqDetector_tb.sv
`timescale 1ns/1ps
module keySeqDetector_tb;

  localparam int ADDR_W = 15;
  localparam int CMD_STORE  = 1;
  localparam int CMD_RECALL = 2;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              ceN = 1'b1;
  logic              weN = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic              lowVoltInhibit = 1'b0;
  logic              engineBusy = 1'b0;
  logic              storeReq, recallReq;
  logic [2:0]        progress;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;
  int expQ[$];
  logic prevStore = 1'b0, prevRecall = 1'b0;

  logic [13:0] keyList [5] = '{14'h0E38, 14'h31C7, 14'h03E0, 14'h3C1F, 14'h303F};

  always #2 clk = ~clk;

  keySeqDetector #(.ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN), .addr(addr),
    .lowVoltInhibit(lowVoltInhibit), .engineBusy(engineBusy),
    .storeReq(storeReq), .recallReq(recallReq), .progress(progress)
  );

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Monitor: pops expected commands as pulses appear.
  always @(negedge clk) begin
    if (rstN) begin
      if (storeReq || recallReq) begin
        check("R11 exclusive", int'(storeReq && recallReq), 0);
        if (expQ.size() == 0) begin
          check("R3/R4 unexpected pulse", storeReq ? CMD_STORE : CMD_RECALL, 0);
        end else begin
          check("R3/R4 command kind", storeReq ? CMD_STORE : CMD_RECALL, expQ.pop_front());
        end
      end
      if ((storeReq && prevStore) || (recallReq && prevRecall))
        check("R11 single cycle", 1, 0);
      prevStore  = storeReq;
      prevRecall = recallReq;
    end
  end

  task automatic access(input logic [ADDR_W-1:0] a, input logic isWrite, input int lowCycles);
    @(negedge clk);
    addr = a;
    weN  = ~isWrite;
    ceN  = 1'b0;
    repeat (lowCycles) @(negedge clk);
    ceN = 1'b1;
    repeat (4) @(negedge clk);
    weN = 1'b1;
  endtask

  task automatic runSeq(input logic [ADDR_W-1:0] hiBits, input logic [13:0] last,
                        input int expCmd, input int expProg, input string tag);
    for (int k = 0; k < 5; k++) begin
      access(hiBits | ADDR_W'(keyList[k]), 1'b0, 4);
      check({tag, " R2 step"}, int'(progress), expProg == 0 ? 0 : k + 1);
    end
    if (expCmd != 0) expQ.push_back(expCmd);
    access(hiBits | ADDR_W'(last), 1'b0, 4);
    check({tag, " progress after sixth"}, int'(progress), 0);
    check({tag, " pending commands"}, expQ.size(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 progress", int'(progress), 0);
    check("R1 storeReq", int'(storeReq), 0);
    check("R1 recallReq", int'(recallReq), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    runSeq('0, 14'h0FC0, CMD_STORE, 1, "R3");
    runSeq('0, 14'h0C63, CMD_RECALL, 1, "R4");
    runSeq(15'h4000, 14'h0FC0, CMD_STORE, 1, "R5");

    // R8: pulse lands on the third rising edge after the sixth ceN fall
    for (int k = 0; k < 5; k++) access(ADDR_W'(keyList[k]), 1'b0, 4);
    expQ.push_back(CMD_STORE);
    @(negedge clk);
    addr = ADDR_W'(14'h0FC0);
    ceN = 1'b0;
    @(negedge clk); check("R8 latency edge1", int'(storeReq), 0);
    @(negedge clk); check("R8 latency edge2", int'(storeReq), 0);
    @(negedge clk); check("R8 latency edge3", int'(storeReq), 1);
    ceN = 1'b1;
    repeat (4) @(negedge clk);
    check("R8 latency queue", expQ.size(), 0);

    // R6: write at step 3 aborts
    access(ADDR_W'(keyList[0]), 1'b0, 4);
    access(ADDR_W'(keyList[1]), 1'b0, 4);
    access(ADDR_W'(keyList[2]), 1'b1, 4);
    check("R6 write abort", int'(progress), 0);
    access(ADDR_W'(keyList[3]), 1'b0, 4);
    access(ADDR_W'(keyList[4]), 1'b0, 4);
    access(ADDR_W'(14'h0FC0), 1'b0, 4);
    check("R6 no command", int'(progress), 0);

    // R7: stray read aborts to 0
    access(ADDR_W'(keyList[0]), 1'b0, 4);
    access(ADDR_W'(keyList[1]), 1'b0, 4);
    access(ADDR_W'(15'h1234), 1'b0, 4);
    check("R7 stray abort", int'(progress), 0);

    // R7: aborting read equal to first key restarts at 1
    access(ADDR_W'(keyList[0]), 1'b0, 4);
    access(ADDR_W'(keyList[1]), 1'b0, 4);
    access(ADDR_W'(keyList[0]), 1'b0, 4);
    check("R7 restart at key1", int'(progress), 1);
    for (int k = 1; k < 5; k++) access(ADDR_W'(keyList[k]), 1'b0, 4);
    check("R7 reached final", int'(progress), 5);
    expQ.push_back(CMD_STORE);
    access(ADDR_W'(14'h0FC0), 1'b0, 4);
    check("R7 store after restart", expQ.size(), 0);

    // R8: long low counts once
    access(ADDR_W'(keyList[0]), 1'b0, 20);
    check("R8 long low once", int'(progress), 1);
    access(ADDR_W'(keyList[1]), 1'b0, 4);
    check("R8 next fall counted", int'(progress), 2);
    access(ADDR_W'(15'h0000), 1'b0, 4);

    // R9: inhibit blocks store, not recall
    lowVoltInhibit = 1'b1;
    runSeq('0, 14'h0FC0, 0, 1, "R9 store");
    runSeq('0, 14'h0C63, CMD_RECALL, 1, "R9 recall");
    lowVoltInhibit = 1'b0;

    // R10: busy mid-sequence resets; busy sequence ignored
    access(ADDR_W'(keyList[0]), 1'b0, 4);
    access(ADDR_W'(keyList[1]), 1'b0, 4);
    access(ADDR_W'(keyList[2]), 1'b0, 4);
    engineBusy = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R10 busy clears", int'(progress), 0);
    runSeq('0, 14'h0FC0, 0, 0, "R10 ignored");
    engineBusy = 1'b0;
    repeat (2) @(negedge clk);
    runSeq('0, 14'h0C63, CMD_RECALL, 1, "R10 after busy");

    repeat (8) @(negedge clk);
    check("R3/R4 final queue", expQ.size(), 0);
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule